// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Arbiter

This block sits beside a small 8-bit CPU core and chooses which of five interrupt sources it serves next. The sources are two external request pins, two timer overflow flags and one serial port flag. Two software-visible registers set the arbitration. An enable register holds one mask bit per source and a global gate. A priority register assigns each source to the low or the high level. The arbiter polls the request flags once per machine cycle and masks them. It then offers the CPU a request line and a 3-bit source index.

The CPU accepts the offer with a one-cycle acknowledge and ends a handler with a one-cycle return strobe. The arbiter tracks which levels are in service. A high-level request can interrupt a low-level handler. A high-level handler cannot be interrupted by any request. Within one level, simultaneous requests are served in a fixed order. On acknowledge, the hardware clears edge-mode external flags and timer flags. The serial flag belongs to the serial port and stays set until software clears it there.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, both register readbacks are 0x00, `irq_req_o` is low and `pend_o` is zero, provided the external pins are high and `ser_i` is low.
- R2: Enable register bit 7 is the global gate. Bits 4..0 enable sources 4..0. Bits 6 and 5 read as zero. Only priority register bits 4..0 are stored, and bits 7..5 read as zero.
- R3: While enable bit 7 is 0, `irq_req_o` stays low whatever the other bits and flags hold.
- R4: A source is offered only when its own enable bit is set.
- R5: Sources have fixed indices: external 0 is 0, timer 0 is 1, external 1 is 2, timer 1 is 3 and serial is 4. Within a level, the lowest index that is pending wins, and `irq_vec_o` carries that index.
- R6: An eligible source whose priority bit is 1 (high) beats every eligible low-priority source, whatever their indices.
- R7: While a low-level handler is in service, only high-priority sources are offered. While a high-level handler is in service, nothing is offered.
- R8: Flags reach arbitration only at a machine-cycle strobe (`tick_i` high). A timer flag set in one cycle is first offered after the next strobe.
- R9: Acknowledging timer N clears its flag (`pend_o` bit 1 or 3). Acknowledging an external source in edge mode clears its flag. In edge mode the flag is set by a high-to-low change of the pin between strobes. In level mode the flag follows the inverted pin at each strobe. The serial flag (`pend_o` bit 4) mirrors `ser_i` and is never cleared by acknowledge.
- R10: An acknowledge drops `irq_req_o` in the next cycle, and the request stays low until the next strobe. An acknowledge while `irq_req_o` is low has no effect.
- R11: A return strobe ends the high-level handler if one is in service, and otherwise ends the low-level one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Machine-cycle strobe; flags are polled here |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the enable register, 1 selects the priority register |
| reg_wdata_i | input | 8 | Register write data |
| en_reg_o | output | 8 | Enable register readback |
| pri_reg_o | output | 8 | Priority register readback |
| ext_n_i | input | 2 | External request pins, active low |
| ext_edge_i | input | 2 | Per-pin mode: 1 for edge, 0 for level |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| ser_i | input | 1 | Serial receive-or-transmit flag |
| pend_o | output | 5 | Raw flag state by source index |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 3 | Index of the offered source |
| irq_ack_i | input | 1 | CPU takes the offered interrupt |
| reti_i | input | 1 | CPU leaves the current handler |

## Verification
The arbitration is swept over every combination of five request flags against all 64 settings of the global gate and per-source masks. That sweep separates the global gate from the individual masks and the masks from the polling order. A second sweep crosses every flag pattern with all 32 priority assignments. It shows whether the high level overrides the index order and whether the order still holds inside each level. Directed sequences cover nesting, return order, the polling delay after a strobe, and which flags an acknowledge clears. The expected source comes from a simple arithmetic model in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 5;
  localparam int VEC_W = 3;
  localparam int NEXT  = 2;
  localparam int REG_W = 8;
  typedef logic [NSRC-1:0] src_vec_t;
  typedef enum logic [VEC_W-1:0] {
    SRC_EX0 = 3'd0,
    SRC_TM0 = 3'd1,
    SRC_EX1 = 3'd2,
    SRC_TM1 = 3'd3,
    SRC_SER = 3'd4
  } src_id_e;
endpackage

// File: rtl/irq_flags.sv
module irq_flags
  import irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [NEXT-1:0] ext_n_i,
  input  logic [NEXT-1:0] ext_edge_i,
  input  logic [NEXT-1:0] tmr_ovf_i,
  input  logic            ser_i,
  input  src_vec_t        clr_i,
  output src_vec_t        pend_o,
  output src_vec_t        poll_o
);
  logic [NEXT-1:0] ext_q, ie_q, tf_q, ie_nxt;

  for (genvar g = 0; g < NEXT; g++) begin : g_src
    logic ie_kept;
    assign ie_kept   = ie_q[g] & ~(clr_i[2*g] & ext_edge_i[g]);
    assign ie_nxt[g] = !tick_i        ? ie_kept :
                       ext_edge_i[g]  ? (ie_kept | (ext_q[g] & ~ext_n_i[g])) :
                                        ~ext_n_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ext_q[g] <= 1'b1;
        ie_q[g]  <= 1'b0;
        tf_q[g]  <= 1'b0;
      end else begin
        if (tick_i) ext_q[g] <= ext_n_i[g];
        ie_q[g] <= ie_nxt[g];
        tf_q[g] <= (tf_q[g] & ~clr_i[2*g+1]) | tmr_ovf_i[g];
      end
    end

    // R9
    tmr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[2*g+1] && !tmr_ovf_i[g]) |=> !tf_q[g]);
    // R9
    edge_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[2*g] && ext_edge_i[g] && !tick_i) |=> !ie_q[g]);
  end

  assign pend_o = {ser_i, tf_q[1], ie_q[1], tf_q[0], ie_q[0]};
  assign poll_o = {ser_i, tf_q[1], ie_nxt[1], tf_q[0], ie_nxt[0]};
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
(
  input  src_vec_t               elig_i,
  input  src_vec_t               pri_i,
  input  logic                   allow_lo_i,
  input  logic                   allow_hi_i,
  output logic                   valid_o,
  output logic                   hi_o,
  output logic [VEC_W-1:0]       idx_o
);
  src_vec_t hi_c, lo_c, win;

  assign hi_c = elig_i &  pri_i & {NSRC{allow_hi_i}};
  assign lo_c = elig_i & ~pri_i & {NSRC{allow_lo_i}};
  assign hi_o = |hi_c;
  assign win  = hi_o ? hi_c : lo_c;
  assign valid_o = |win;

  // lowest index wins inside the chosen level
  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (win[i]) idx_o = VEC_W'(i);
  end

  always_comb begin
    // R5
    if (valid_o) vec_range_chk: assert (idx_o < VEC_W'(NSRC));
  end
endmodule

// File: rtl/irq_ins.sv
module irq_ins (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic take_hi_i,
  input  logic reti_i,
  output logic ins_lo_o,
  output logic ins_hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_lo_o <= 1'b0;
      ins_hi_o <= 1'b0;
    end else if (take_i) begin
      if (take_hi_i) ins_hi_o <= 1'b1;
      else           ins_lo_o <= 1'b1;
    end else if (reti_i) begin
      if (ins_hi_o) ins_hi_o <= 1'b0;
      else          ins_lo_o <= 1'b0;
    end
  end

  // R11
  reti_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take_i && ins_hi_o) |=> (!ins_hi_o && ins_lo_o == $past(ins_lo_o)));
  // R7
  nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (!ins_hi_o && !(ins_lo_o && !take_hi_i)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] en_reg_o,
  output logic [REG_W-1:0] pri_reg_o,
  input  logic [NEXT-1:0]  ext_n_i,
  input  logic [NEXT-1:0]  ext_edge_i,
  input  logic [NEXT-1:0]  tmr_ovf_i,
  input  logic             ser_i,
  output logic [NSRC-1:0]  pend_o,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o,
  input  logic             irq_ack_i,
  input  logic             reti_i
);
  localparam int GATE_BIT = REG_W - 1;

  logic     gate_q;
  src_vec_t en_q, pri_q, samp_q, poll, clr, elig;
  logic     ins_lo, ins_hi, valid, pick_hi, take;
  logic [VEC_W-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      en_q   <= '0;
      pri_q  <= '0;
    end else if (reg_we_i) begin
      if (!reg_sel_i) begin
        gate_q <= reg_wdata_i[GATE_BIT];
        en_q   <= reg_wdata_i[NSRC-1:0];
      end else begin
        pri_q  <= reg_wdata_i[NSRC-1:0];
      end
    end
  end

  assign en_reg_o  = {gate_q, {(REG_W-NSRC-1){1'b0}}, en_q};
  assign pri_reg_o = {{(REG_W-NSRC){1'b0}}, pri_q};

  irq_flags u_flags (
    .clk_i, .rst_ni, .tick_i, .ext_n_i, .ext_edge_i, .tmr_ovf_i, .ser_i,
    .clr_i(clr), .pend_o, .poll_o(poll)
  );

  // acknowledge wins over a coincident poll: nothing is offered until next tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     samp_q <= '0;
    else if (take)   samp_q <= '0;
    else if (tick_i) samp_q <= poll;
  end

  assign elig = samp_q & en_q & {NSRC{gate_q}};

  irq_pick u_pick (
    .elig_i(elig), .pri_i(pri_q),
    .allow_lo_i(!ins_hi && !ins_lo), .allow_hi_i(!ins_hi),
    .valid_o(valid), .hi_o(pick_hi), .idx_o(idx)
  );

  assign irq_req_o = valid;
  assign irq_vec_o = idx;
  assign take      = irq_ack_i & valid;
  assign clr       = take ? src_vec_t'(1) << idx : '0;

  irq_ins u_ins (
    .clk_i, .rst_ni, .take_i(take), .take_hi_i(pick_hi), .reti_i,
    .ins_lo_o(ins_lo), .ins_hi_o(ins_hi)
  );

  // R3
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> en_reg_o[GATE_BIT]);
  // R10
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o) |=> !irq_req_o);
  // R7
  hi_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_hi |-> !irq_req_o);
  // R4
  mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> en_reg_o[irq_vec_o]);
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, we = 0, sel = 0, ser = 0, ack = 0, reti = 0;
  logic [7:0] wdata = '0;
  logic [1:0] ext_n = 2'b11, ext_edge = 2'b00, ovf = 2'b00;
  logic [7:0] en_rb, pri_rb;
  logic [4:0] pend;
  logic req;
  logic [2:0] vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .en_reg_o(en_rb), .pri_reg_o(pri_rb), .ext_n_i(ext_n),
    .ext_edge_i(ext_edge), .tmr_ovf_i(ovf), .ser_i(ser), .pend_o(pend),
    .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack), .reti_i(reti)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    we = 1; sel = s; wdata = d; @(negedge clk); we = 0;
  endtask
  task automatic do_tick(); tick = 1; @(negedge clk); tick = 0; endtask
  task automatic do_ack();  ack = 1;  @(negedge clk); ack = 0;  endtask
  task automatic do_reti(); reti = 1; @(negedge clk); reti = 0; endtask
  task automatic pulse(input logic [1:0] b); ovf = b; @(negedge clk); ovf = 0; endtask

  function automatic int model(input int g, input int m, input int p, input int f);
    int e, h;
    e = g ? (f & m) : 0;
    h = e & p;
    if (h != 0) e = h;
    if (e == 0) return -1;
    for (int i = 0; i < 5; i++) if (e[i]) return i;
    return -1;
  endfunction

  task automatic drain();
    ext_n = 2'b11; ser = 0;
    wr(0, 8'h9F);
    do_tick();
    repeat (6) if (req) begin do_ack(); do_reti(); do_tick(); end
  endtask

  task automatic run_case(input int g, input int m, input int p, input int f, input string tag);
    int e;
    wr(0, {g[0], 2'b00, m[4:0]});
    wr(1, p[7:0]);
    ext_n = {~f[2], ~f[0]}; ser = f[4];
    pulse({f[3], f[1]});
    do_tick();
    e = model(g, m, p, f);
    check(tag, req, e >= 0);
    if (e >= 0) check(tag, vec, e);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 en", en_rb, 0);
    check("R1 pri", pri_rb, 0);
    check("R1 req", req, 0);
    check("R1 pend", pend, 0);
    // R2
    wr(0, 8'hFF); check("R2 en", en_rb, 8'h9F);
    wr(1, 8'hFF); check("R2 pri", pri_rb, 8'h1F);
    wr(1, 8'h00);

    // R3 R4 R5: gate and masks against all flag patterns
    for (int g = 0; g < 2; g++)
      for (int m = 0; m < 32; m++)
        for (int f = 0; f < 32; f++)
          run_case(g, m, 0, f, g ? "R4 R5 mask/order" : "R3 gate");
    // R6 R5: priority against all flag patterns
    for (int p = 0; p < 32; p++)
      for (int f = 0; f < 32; f++)
        run_case(1, 31, p, f, "R6 priority");

    // R8 R10: timer flag polled only at a strobe; ack without request ignored
    wr(0, 8'h9F); wr(1, 8'h00);
    pulse(2'b01);
    check("R8 pend", pend[1], 1);
    repeat (3) @(negedge clk);
    check("R8 no tick", req, 0);
    do_ack();
    check("R10 stray ack", pend[1], 1);
    do_tick();
    check("R8 req", req, 1);
    check("R8 vec", vec, 1);
    do_ack();
    check("R10 drop", req, 0);
    check("R9 tmr clr", pend[1], 0);
    do_reti();

    // R9 edge mode external 0
    ext_edge = 2'b01;
    do_tick();
    ext_n[0] = 0;
    do_tick();
    check("R9 edge set", pend[0], 1);
    check("R9 edge vec", vec, 0);
    ext_n[0] = 1;
    do_ack();
    check("R9 edge clr", pend[0], 0);
    do_reti();
    do_tick();
    check("R9 no new edge", req, 0);
    ext_edge = 2'b00;

    // R9 serial flag kept across acknowledge
    ser = 1;
    do_tick();
    check("R9 ser vec", vec, 4);
    do_ack();
    check("R9 ser kept", pend[4], 1);
    check("R10 ser drop", req, 0);
    do_reti();
    do_tick();
    check("R9 ser again", req, 1);
    ser = 0;
    do_ack(); do_reti();
    drain();

    // R7 R11 nesting: serial high, timers low
    wr(0, 8'h9F); wr(1, 8'h10);
    pulse(2'b01); do_tick();
    check("R7 lo vec", vec, 1);
    do_ack();
    pulse(2'b10); do_tick();
    check("R7 lo blocks lo", req, 0);
    ser = 1; do_tick();
    check("R7 hi preempts", req, 1);
    check("R7 hi vec", vec, 4);
    do_ack();
    pulse(2'b01); do_tick();
    check("R7 hi blocks all", req, 0);
    ser = 0;
    do_reti();
    do_tick();
    check("R11 lo still in service", req, 0);
    do_reti();
    do_tick();
    check("R11 both ended", req, 1);
    check("R11 vec", vec, 1);
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule